// File: doc/BRIEF.md
# Command-Sequence Erase Controller for a Byte-Wide Nonvolatile Array

This block models a byte-wide nonvolatile memory array held in on-chip registers. It sits on a parallel bus with active-low chip enable, output enable and write strobe. A byte load stores the data byte at the addressed location. A read returns the byte at the addressed location. The full device has 32K locations on a 15-bit address. The array depth comes from `ADDR_W`, which defaults to 12 bits so that the default build stays small.

A command matcher watches every byte load. Six consecutive loads with the right address/data pairs start a whole-array erase. The first of these loads carries data AAH at unlock address A, and the remaining pairs are parameters. Once the erase starts, the block runs on its own for `ERASE_CYC` clock cycles, sets every location to FFH, and ignores every load. Software polls for completion: a read during this window returns a status byte instead of array data.

The same matcher also handles the write lock:
- A three-load code sets the lock.
- A six-load code whose last byte is 20H clears it.
- While the lock is set, loads do not alter the array.

Power-up windows delay the first accepted read and the first accepted load.

Top module: `eeprom_erase_ctrl`

## Requirements
- R1: The erase starts after six accepted loads: AAH at address A, 55H at address B, 80H at A, AAH at A, 55H at B and 10H at A. The addresses A and B and every data byte except the first come from parameters. In the default build A is 555H and B is AAAH.
- R2: An accepted load that is not the expected next step returns the matcher to step one. If that load equals the step-one pair (AAH at A), it is counted as step one of a new sequence.
- R3: After an erase completes, every location reads FFH.
- R4: The busy period starts on the clock edge that accepts the sixth load and lasts exactly `ERASE_CYC` clock edges. Reads that sample on those edges return the status byte. Later reads return array data.
- R5: During the busy period, loads change neither the array nor the matcher step nor the stored last-loaded byte.
- R6: The lock code is AAH at A, 55H at B, then A0H at A. It sets the lock. While the lock is set, loads leave the array unchanged. An erase leaves the lock set. The six-step code ending in 20H at A clears the lock.
- R7: The busy status byte is built as follows. Bit 7 is the inverse of bit 7 of the last accepted load. Bit 6 reads 0 on the first busy read after the erase starts and changes on each busy read after that. Bits 5..0 read 0.
- R8: Reads are ignored until `RD_WAIT` edges after reset: `dq_oe` stays 0 and `dout` keeps its value. Loads are ignored until `WR_WAIT` edges after reset.
- R9: A load is the first cycle with `ce_n`=0, `we_n`=0 and `oe_n`=1. When the lock is clear, it writes `din` to `addr` on that edge. A read is the first cycle with `ce_n`=0, `oe_n`=0 and `we_n`=1. It updates `dout` on that edge. `dq_oe` is 1 in the cycle after each edge where the read condition holds and reads are allowed.
- R10: During reset `dout` is 0 and `dq_oe` is 0. After reset the lock is clear, the matcher is at step one and no erase is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Load data |
| dout | output | 8 | Read data or busy status |
| dq_oe | output | 1 | Read data is being driven |

## Verification
A wrong matcher step makes the block fail to enter busy, or enter it when it should not. This shows on the next read, as a status byte where data was expected or the reverse. A miscounted busy period moves the status-to-data change of the polled reads by at least one read. A stray toggle flip inverts bit 6 on every later busy read. Lock or sweep faults appear as a wrong byte on the first readback of an affected location. The reference model is compared against `dout` and `dq_oe` on every clock, so each fault surfaces within a few cycles of the stimulus that exposes it.

// File: rtl/eeprom_erase_ctrl.sv
module eeprom_erase_ctrl #(
  parameter int ADDR_W = 12,
  parameter logic [6*ADDR_W-1:0] SEQ_A = {12'h555, 12'hAAA, 12'h555, 12'h555, 12'hAAA, 12'h555},
  parameter logic [47:0] SEQ_D = 48'hAA_55_80_AA_55_10,
  parameter logic [7:0] LOCK_D = 8'hA0,
  parameter logic [7:0] UNLOCK_D = 8'h20,
  parameter int ERASE_CYC = 4_000_000,
  parameter int WR_WAIT = 1_000_000,
  parameter int RD_WAIT = 20_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dq_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW = $clog2(ERASE_CYC + 1);
  localparam int PW = $clog2(WR_WAIT + 1);
  localparam logic [CW-1:0] ELAST = CW'(ERASE_CYC - 1);

  function automatic logic [ADDR_W-1:0] step_a(input int k);
    return SEQ_A[(5-k)*ADDR_W +: ADDR_W];
  endfunction
  function automatic logic [7:0] step_d(input int k);
    return SEQ_D[(5-k)*8 +: 8];
  endfunction

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] pu_cnt;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    last_d;
  logic          ld_q, rd_q, busy, locked, tog;

  wire ld_cond = !ce_n && !we_n && oe_n;
  wire rd_cond = !ce_n && !oe_n && we_n;
  wire ld_ev   = ld_cond && !ld_q;
  wire rd_ev   = rd_cond && !rd_q;
  wire wr_ok   = (pu_cnt == PW'(WR_WAIT));
  wire rd_ok   = (pu_cnt >= PW'(RD_WAIT));
  wire ld_ok   = ld_ev && wr_ok && !busy;

  wire hit        = (addr == step_a(int'(idx))) && (din == step_d(int'(idx)));
  wire hit0       = (addr == step_a(0)) && (din == step_d(0));
  wire lock_hit   = (idx == 3'd2) && (addr == step_a(2)) && (din == LOCK_D);
  wire unlock_hit = (idx == 3'd5) && (addr == step_a(5)) && (din == UNLOCK_D);

  wire       sweep_we = busy && (cnt < CW'(DEPTH));
  wire [7:0] status   = {~last_d[7], tog, 6'b0};

  always_ff @(posedge clk) begin
    if (sweep_we) mem[cnt[ADDR_W-1:0]] <= 8'hFF;
    else if (ld_ok && !locked) mem[addr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_cnt <= '0;
      ld_q   <= 1'b0;
      rd_q   <= 1'b0;
      idx    <= '0;
      locked <= 1'b0;
      busy   <= 1'b0;
      cnt    <= '0;
      last_d <= '0;
      tog    <= 1'b0;
      dout   <= '0;
      dq_oe  <= 1'b0;
    end else begin
      if (!wr_ok) pu_cnt <= pu_cnt + 1'b1;
      ld_q  <= ld_cond;
      rd_q  <= rd_cond;
      dq_oe <= rd_cond && rd_ok;
      if (rd_ev && rd_ok) begin
        if (busy) begin
          dout <= status;
          tog  <= ~tog;
        end else begin
          dout <= mem[addr];
        end
      end
      if (busy) begin
        if (cnt == ELAST) busy <= 1'b0;
        else cnt <= cnt + 1'b1;
      end
      if (ld_ok) begin
        last_d <= din;
        if (lock_hit) begin
          locked <= 1'b1;
          idx    <= '0;
        end else if (unlock_hit) begin
          locked <= 1'b0;
          idx    <= '0;
        end else if (hit && idx == 3'd5) begin
          idx  <= '0;
          busy <= 1'b1;
          cnt  <= '0;
          tog  <= 1'b0;
        end else if (hit) begin
          idx <= idx + 1'b1;
        end else if (hit0) begin
          idx <= 3'd1;
        end else begin
          idx <= '0;
        end
      end
    end
  end

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == ELAST));

  p_load_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ld_ev) |=> (idx == $past(idx) && last_d == $past(last_d)));

  p_lock_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(locked));

  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_ev && rd_ok) |=> (tog != $past(tog)));

  p_early_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |-> (idx == 3'd0 && !busy && !locked));

  p_early_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> !dq_oe);
endmodule

// File: tb/eeprom_erase_ctrl_tb_top.sv
module eeprom_erase_ctrl_tb_top;
  localparam int AW = 6;
  localparam int EC = 100;
  localparam int WW = 40;
  localparam int RW = 10;
  localparam int A = 'h15;
  localparam int B = 'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dq_oe;

  always #2.5 clk = ~clk;

  eeprom_erase_ctrl #(
    .ADDR_W(AW), .SEQ_A({6'h15, 6'h2A, 6'h15, 6'h15, 6'h2A, 6'h15}),
    .ERASE_CYC(EC), .WR_WAIT(WW), .RD_WAIT(RW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe)
  );

  int errors = 0, checks = 0;
  bit fin = 0;
  string cur_req = "R10";

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!fin) begin
      fin = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // reference model
  int m_mem[64];
  int sa[6] = '{A, B, A, A, B, A};
  int sd[6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h10};
  int m_step = 0, m_left = 0, m_last = 0, m_edges = 0, m_dout = 0;
  bit m_lock = 0, m_tog = 0, m_ldp = 0, m_rdp = 0, m_oe = 0;

  initial foreach (m_mem[i]) m_mem[i] = -1;

  always @(posedge clk or negedge rst_n) begin
    bit ldc, rdc, ldev, rdev, bz, wok, rok;
    int a, d;
    if (!rst_n) begin
      m_step = 0; m_left = 0; m_last = 0; m_edges = 0; m_dout = 0;
      m_lock = 0; m_tog = 0; m_ldp = 0; m_rdp = 0; m_oe = 0;
    end else begin
      a = int'(addr); d = int'(din);
      ldc = !ce_n && !we_n && oe_n;
      rdc = !ce_n && !oe_n && we_n;
      ldev = ldc && !m_ldp; rdev = rdc && !m_rdp;
      m_ldp = ldc; m_rdp = rdc;
      wok = (m_edges >= WW); rok = (m_edges >= RW);
      if (m_edges < WW) m_edges++;
      bz = (m_left > 0);
      if (bz) m_left--;
      m_oe = rdc && rok;
      if (rdev && rok) begin
        if (bz) begin
          m_dout = (m_last >= 128 ? 0 : 128) + (m_tog ? 64 : 0);
          m_tog = !m_tog;
        end else m_dout = m_mem[a];
      end
      if (ldev && wok && !bz) begin
        if (!m_lock) m_mem[a] = d;
        m_last = d;
        if (m_step == 2 && a == sa[2] && d == 'hA0) begin m_lock = 1; m_step = 0; end
        else if (m_step == 5 && a == sa[5] && d == 'h20) begin m_lock = 0; m_step = 0; end
        else if (a == sa[m_step] && d == sd[m_step]) begin
          if (m_step == 5) begin
            m_step = 0; m_left = EC; m_tog = 0;
            foreach (m_mem[i]) m_mem[i] = 'hFF;
          end else m_step++;
        end
        else if (a == sa[0] && d == sd[0]) m_step = 1;
        else m_step = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk({cur_req, " dq_oe"}, int'(dq_oe), int'(m_oe));
      if (m_dout >= 0) chk({cur_req, " dout"}, int'(dout), m_dout);
    end
  end

  task automatic ld(input int a, input int d);
    @(negedge clk);
    ce_n = 0; we_n = 0; oe_n = 1; addr = AW'(a); din = 8'(d);
    @(negedge clk);
    ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input int a, output int v, output int oe);
    @(negedge clk);
    ce_n = 0; oe_n = 0; we_n = 1; addr = AW'(a);
    @(negedge clk);
    v = int'(dout); oe = int'(dq_oe);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic erase_code(input int last);
    ld(A, 'hAA); ld(B, 'h55); ld(A, 'h80); ld(A, 'hAA); ld(B, 'h55); ld(A, last);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    int v, oe;
    repeat (3) @(negedge clk);
    chk("R10 reset dout", int'(dout), 0);
    chk("R10 reset dq_oe", int'(dq_oe), 0);
    rst_n = 1;

    cur_req = "R8";
    rd(7, v, oe);
    chk("R8 early read oe", oe, 0);
    chk("R8 early read dout", v, 0);
    ld(A, 'hAA); ld(B, 'h55); ld(A, 'hA0);
    repeat (WW) @(negedge clk);
    ld(7, 'h33); rd(7, v, oe);
    chk("R8 early lock ignored", v, 'h33);
    chk("R9 read oe", oe, 1);

    cur_req = "R9";
    for (int i = 0; i < 6; i++) ld(i, (i * 37 + 1) & 255);
    for (int i = 0; i < 6; i++) begin
      rd(i, v, oe);
      chk("R9 readback", v, (i * 37 + 1) & 255);
    end

    cur_req = "R2";
    ld(A, 'hAA); ld(B, 'h55); ld(A, 'h33);
    ld(A, 'h80); ld(A, 'hAA); ld(B, 'h55); ld(A, 'h10);
    rd(7, v, oe);
    chk("R2 broken code no erase", v, 'h33);
    ld(A, 'hAA); ld(B, 'h55); ld(A, 'hAA);
    ld(B, 'h55); ld(A, 'h80); ld(A, 'hAA); ld(B, 'h55); ld(A, 'h10);

    cur_req = "R7";
    rd(7, v, oe); chk("R7 R1 first poll", v, 'h80);
    rd(0, v, oe); chk("R7 second poll", v, 'hC0);

    cur_req = "R5";
    ld(3, 'h00); ld(A, 'hAA); ld(B, 'h55);
    repeat (EC + 5) @(negedge clk);
    rd(3, v, oe); chk("R5 busy load ignored", v, 'hFF);
    ld(A, 'h80); ld(A, 'hAA); ld(B, 'h55); ld(A, 'h10);
    rd(7, v, oe); chk("R5 matcher not advanced", v, 'hFF);

    cur_req = "R3";
    for (int i = 0; i < 64; i++) begin
      if (i != A && i != B) begin
        rd(i, v, oe); chk("R3 erased", v, 'hFF);
      end
    end

    cur_req = "R4";
    erase_code('h10);
    for (int j = 0; j < 50; j++) begin
      rd(7, v, oe); chk("R4 R7 status", v, 'h80 + ((j & 1) * 64));
    end
    rd(7, v, oe); chk("R4 data after busy", v, 'hFF);

    cur_req = "R6";
    ld(A, 'hAA); ld(B, 'h55); ld(A, 'hA0);
    ld(9, 'h44); rd(9, v, oe); chk("R6 locked write", v, 'hFF);
    erase_code('h10);
    repeat (EC + 5) @(negedge clk);
    ld(9, 'h55); rd(9, v, oe); chk("R6 lock kept after erase", v, 'hFF);
    erase_code('h20);
    ld(9, 'h66); rd(9, v, oe); chk("R6 unlocked write", v, 'h66);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule